// File: doc/BRIEF.md
# Link-Load / Conditional-Store Reservation Unit

This unit sits next to a 32-bit load/store pipeline and executes the two atomic memory operations: a link-load, which reads a word and records a reservation on its address, and a conditional store, which writes a word only if that reservation is still held. It decodes both operations straight from the instruction word and names the register-file entries it needs. It adds the base register to the operation's signed immediate to form the effective address. It then either finishes at once or sends a single request to memory over a valid/ready port and waits for the response.

Results come back as one-cycle pulses. A link-load returns a register write-back. A conditional store returns an update of the condition flag: 1 when the store took place and 0 when it did not. The unit can also pulse an alignment fault or a memory-access fault. The pipeline drives `exc_taken` whenever it enters any exception handler and `ctx_switch` whenever it switches tasks. Either input cancels the reservation, so a conditional store after an interruption always fails.

Top module: `llsc_resv_unit`

## Requirements
- R1: Only opcode field `op_insn[31:26]` = 0x1B (link-load) or 0x33 (conditional store) is acted on. Any other accepted word causes no memory request, no result pulse and no change to the reservation.
- R2: Link-load fields: destination index `[25:21]`, base index `[20:16]`. The effective address is the base value plus `[15:0]` sign-extended to 32 bits.
- R3: Conditional-store fields: base index `[20:16]`, data index `[15:11]`. The immediate is `{[25:21],[10:0]}` (16 bits), sign-extended, and is added to the base value.
- R4: A link-load whose address has nonzero bits `[1:0]` pulses `align_fault` in the cycle after acceptance. It issues no memory request and leaves the reservation unchanged.
- R5: An aligned link-load issues one read (`mem_req_write`=0) at its address. On a good response it pulses `wb_valid` with the read word and the destination index, sets the reservation and records the address.
- R6: A conditional store with no reservation, or whose address does not match the recorded one, issues no request. It pulses `cflag_we` with `cflag_val`=0 in the cycle after acceptance.
- R7: The match ignores the low `RESV_GRAN` address bits (0 means exact equality). The match is tested before alignment. A matching store whose bits `[1:0]` are nonzero pulses `align_fault` and issues no request.
- R8: A matching, aligned conditional store writes the data register value to its address. On a good response it pulses `cflag_we` with `cflag_val`=1 and clears the reservation.
- R9: `exc_taken` or `ctx_switch` high at a clock edge clears the reservation. This takes priority over a link-load setting it at the same edge.
- R10: A response with `mem_rsp_err`=1 pulses `access_fault` instead of any other result and leaves the reservation unchanged.
- R11: In and after reset, the reservation is clear, `op_ready`=1, no request is pending and no result pulse is high. At most one result pulse is high in any cycle.
- R12: While `mem_req_valid`=1 and `mem_req_ready`=0, the request stays valid and its address, direction and write data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Instruction word offered |
| op_ready | output | 1 | Unit idle and accepting an instruction |
| op_insn | input | 32 | Instruction word |
| base_idx | output | 5 | Register index of the base operand |
| data_idx | output | 5 | Register index of the store data |
| base_val | input | DATA_W | Value read at `base_idx` |
| data_val | input | DATA_W | Value read at `data_idx` |
| exc_taken | input | 1 | Exception entry; cancels the reservation |
| ctx_switch | input | 1 | Context switch; cancels the reservation |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | DATA_W | Request word address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_rdata | input | DATA_W | Read data |
| mem_rsp_err | input | 1 | Access faulted |
| wb_valid | output | 1 | Register write-back pulse |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | DATA_W | Write-back data |
| cflag_we | output | 1 | Condition-flag update pulse |
| cflag_val | output | 1 | New condition-flag value |
| align_fault | output | 1 | Alignment fault pulse |
| access_fault | output | 1 | Memory-access fault pulse |

## Verification
The bench builds the unit with `RESV_GRAN`=2 and leaves the data width and both opcodes at their defaults. With word-granular matching, an aligned link-load at one word can be matched by a misaligned conditional store inside that same word. That reaches the ordering in which the match is tested before alignment. With the exact-match default, this path cannot be reached, because a misaligned link-load never sets a reservation. The bench also points accesses at an address that faults, and holds the exception input high across a whole link-load, so that the priority of cancellation over setting comes into play.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_RSP  = 2'd2
   } llsc_state_e;

   localparam int unsigned INSN_W = 32;
   localparam int unsigned IDX_W  = 5;
   localparam int unsigned IMM_W  = 16;
   localparam logic [5:0]  OPC_LINK_LOAD  = 6'h1B;
   localparam logic [5:0]  OPC_COND_STORE = 6'h33;
endpackage

// File: rtl/llsc_decode.sv
module llsc_decode
   import llsc_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter logic [5:0]  OPC_LL  = OPC_LINK_LOAD,
   parameter logic [5:0]  OPC_SC  = OPC_COND_STORE
) (
   input  logic [INSN_W-1:0] insn,
   input  logic [DATA_W-1:0] base_val,
   output logic              is_ll,
   output logic              is_sc,
   output logic [IDX_W-1:0]  dst_idx,
   output logic [IDX_W-1:0]  base_idx,
   output logic [IDX_W-1:0]  data_idx,
   output logic [DATA_W-1:0] eff_addr,
   output logic              misaligned
);
   localparam int unsigned EXT_W = DATA_W - IMM_W;

   logic [IMM_W-1:0] imm;

   always_comb begin
      is_ll    = (insn[31:26] == OPC_LL);
      is_sc    = (insn[31:26] == OPC_SC);
      dst_idx  = insn[25:21];
      base_idx = insn[20:16];
      data_idx = insn[15:11];
      // the conditional store splits its offset around the data index
      imm      = is_sc ? {insn[25:21], insn[10:0]} : insn[15:0];
      eff_addr = base_val + {{EXT_W{imm[IMM_W-1]}}, imm};
      misaligned = |eff_addr[1:0];
   end
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned GRAN   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [DATA_W-1:0] set_addr,
   input  logic              clr_en,
   input  logic              kill,
   input  logic [DATA_W-1:0] cmp_addr,
   output logic              flag,
   output logic              match
);
   logic [DATA_W-1:0] held_addr;
   logic              addr_hit;

   generate
      if (GRAN == 0) begin : g_exact
         assign addr_hit = (cmp_addr == held_addr);
      end else begin : g_coarse
         assign addr_hit = (cmp_addr[DATA_W-1:GRAN] == held_addr[DATA_W-1:GRAN]);
      end
   endgenerate

   assign match = flag && addr_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag      <= 1'b0;
         held_addr <= '0;
      end else begin
         if (kill)        flag <= 1'b0;
         else if (set_en) flag <= 1'b1;
         else if (clr_en) flag <= 1'b0;
         if (set_en) held_addr <= set_addr;
      end
   end
endmodule

// File: rtl/llsc_resv_unit.sv
module llsc_resv_unit
   import llsc_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned RESV_GRAN = 0,
   parameter logic [5:0]  OPC_LL    = OPC_LINK_LOAD,
   parameter logic [5:0]  OPC_SC    = OPC_COND_STORE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   output logic              op_ready,
   input  logic [31:0]       op_insn,
   output logic [4:0]        base_idx,
   output logic [4:0]        data_idx,
   input  logic [DATA_W-1:0] base_val,
   input  logic [DATA_W-1:0] data_val,
   input  logic              exc_taken,
   input  logic              ctx_switch,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [DATA_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_rdata,
   input  logic              mem_rsp_err,
   output logic              wb_valid,
   output logic [4:0]        wb_idx,
   output logic [DATA_W-1:0] wb_data,
   output logic              cflag_we,
   output logic              cflag_val,
   output logic              align_fault,
   output logic              access_fault
);
   generate
      if (DATA_W < IMM_W) begin : g_bad_width
         $error("llsc_resv_unit: DATA_W must be at least the immediate width");
      end
      if (RESV_GRAN > 2) begin : g_bad_gran
         $error("llsc_resv_unit: RESV_GRAN above word granularity");
      end
   endgenerate

   llsc_state_e       state;
   logic              cur_sc;
   logic [IDX_W-1:0]  cur_idx;
   logic              dec_ll, dec_sc, dec_mis;
   logic [IDX_W-1:0]  dec_dst;
   logic [DATA_W-1:0] dec_ea;
   logic              resv_flag, resv_match;
   logic              rsp_good;

   llsc_decode #(.DATA_W(DATA_W), .OPC_LL(OPC_LL), .OPC_SC(OPC_SC)) u_dec (
      .insn       (op_insn),
      .base_val   (base_val),
      .is_ll      (dec_ll),
      .is_sc      (dec_sc),
      .dst_idx    (dec_dst),
      .base_idx   (base_idx),
      .data_idx   (data_idx),
      .eff_addr   (dec_ea),
      .misaligned (dec_mis)
   );

   assign rsp_good = (state == ST_RSP) && mem_rsp_valid && !mem_rsp_err;

   llsc_resv #(.DATA_W(DATA_W), .GRAN(RESV_GRAN)) u_resv (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (rsp_good && !cur_sc),
      .set_addr (mem_req_addr),
      .clr_en   (rsp_good && cur_sc),
      .kill     (exc_taken || ctx_switch),
      .cmp_addr (dec_ea),
      .flag     (resv_flag),
      .match    (resv_match)
   );

   assign op_ready      = (state == ST_IDLE);
   assign mem_req_valid = (state == ST_REQ);
   assign mem_req_write = cur_sc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         cur_sc        <= 1'b0;
         cur_idx       <= '0;
         mem_req_addr  <= '0;
         mem_req_wdata <= '0;
         wb_valid      <= 1'b0;
         wb_idx        <= '0;
         wb_data       <= '0;
         cflag_we      <= 1'b0;
         cflag_val     <= 1'b0;
         align_fault   <= 1'b0;
         access_fault  <= 1'b0;
      end else begin
         wb_valid     <= 1'b0;
         cflag_we     <= 1'b0;
         align_fault  <= 1'b0;
         access_fault <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (op_valid && dec_ll) begin
                  if (dec_mis) begin
                     align_fault <= 1'b1;
                  end else begin
                     state         <= ST_REQ;
                     cur_sc        <= 1'b0;
                     cur_idx       <= dec_dst;
                     mem_req_addr  <= dec_ea;
                     mem_req_wdata <= '0;
                  end
               end else if (op_valid && dec_sc) begin
                  if (!resv_match) begin
                     cflag_we  <= 1'b1;
                     cflag_val <= 1'b0;
                  end else if (dec_mis) begin
                     align_fault <= 1'b1;
                  end else begin
                     state         <= ST_REQ;
                     cur_sc        <= 1'b1;
                     mem_req_addr  <= dec_ea;
                     mem_req_wdata <= data_val;
                  end
               end
            end
            ST_REQ: begin
               if (mem_req_ready) state <= ST_RSP;
            end
            ST_RSP: begin
               if (mem_rsp_valid) begin
                  state <= ST_IDLE;
                  if (mem_rsp_err) begin
                     access_fault <= 1'b1;
                  end else if (cur_sc) begin
                     cflag_we  <= 1'b1;
                     cflag_val <= 1'b1;
                  end else begin
                     wb_valid <= 1'b1;
                     wb_idx   <= cur_idx;
                     wb_data  <= mem_rsp_rdata;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/llsc_resv_unit_chk.sv
module llsc_resv_unit_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              kill,
   input logic              resv_flag,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic              mem_req_write,
   input logic [DATA_W-1:0] mem_req_addr,
   input logic [DATA_W-1:0] mem_req_wdata,
   input logic              wb_valid,
   input logic              cflag_we,
   input logic              cflag_val,
   input logic              align_fault,
   input logic              access_fault
);
   a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

   a_r11_one_result: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wb_valid, cflag_we, align_fault, access_fault}));

   a_r4_align_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> !mem_req_valid);

   a_r6_fail_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (cflag_we && !cflag_val) |-> !mem_req_valid);

   a_r9_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> !resv_flag);

   a_r5_wb_holds_resv: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !$past(kill)) |-> resv_flag);

   a_r8_sc_ok_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cflag_we && cflag_val) |-> !resv_flag);

   a_r10_fault_keeps_resv: assert property (@(posedge clk) disable iff (!rst_n)
      (access_fault && !$past(kill)) |-> $stable(resv_flag));
endmodule

bind llsc_resv_unit llsc_resv_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .kill          (exc_taken || ctx_switch),
   .resv_flag     (resv_flag),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_write (mem_req_write),
   .mem_req_addr  (mem_req_addr),
   .mem_req_wdata (mem_req_wdata),
   .wb_valid      (wb_valid),
   .cflag_we      (cflag_we),
   .cflag_val     (cflag_val),
   .align_fault   (align_fault),
   .access_fault  (access_fault)
);

// File: tb/llsc_resv_unit_test.sv
module llsc_resv_unit_test;
   localparam int K_WB = 0, K_CF = 1, K_AL = 2, K_AC = 3;

   typedef struct packed {
      logic [1:0]  kind;
      logic [4:0]  idx;
      logic [31:0] val;
   } exp_t;

   typedef struct packed {
      logic        wr;
      logic [31:0] addr;
      logic [31:0] wd;
   } rq_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic op_valid = 1'b0;
   logic [31:0] op_insn = '0;
   logic exc_taken = 1'b0, ctx_switch = 1'b0;
   logic op_ready;
   logic [4:0] base_idx, data_idx;
   logic [31:0] base_val, data_val;
   logic mem_req_valid, mem_req_write, mem_req_ready;
   logic [31:0] mem_req_addr, mem_req_wdata;
   logic mem_rsp_valid, mem_rsp_err;
   logic [31:0] mem_rsp_rdata;
   logic wb_valid, cflag_we, cflag_val, align_fault, access_fault;
   logic [4:0] wb_idx;
   logic [31:0] wb_data;

   logic [31:0] regs [32];
   logic [31:0] mem_arr [64];
   logic req_wait = 1'b0, rsp_pend = 1'b0, rsp_e = 1'b0;
   logic [31:0] rsp_d = '0;

   int total = 0, bad = 0, pulses = 0, reqs = 0;
   bit timeout = 0;
   bit m_flag = 0;
   logic [31:0] m_addr = '0;
   exp_t exp_q[$];
   string tag_q[$];
   rq_t  rq_q[$];

   always #10 clk = ~clk;

   assign base_val = regs[base_idx];
   assign data_val = regs[data_idx];
   assign mem_req_ready = req_wait;
   assign mem_rsp_valid = rsp_pend;
   assign mem_rsp_err   = rsp_e;
   assign mem_rsp_rdata = rsp_d;

   llsc_resv_unit #(.RESV_GRAN(2)) uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .op_insn(op_insn), .base_idx(base_idx), .data_idx(data_idx),
      .base_val(base_val), .data_val(data_val),
      .exc_taken(exc_taken), .ctx_switch(ctx_switch),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_err(mem_rsp_err),
      .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
      .cflag_we(cflag_we), .cflag_val(cflag_val),
      .align_fault(align_fault), .access_fault(access_fault)
   );

   // memory: ready on the second cycle of a request, reply one cycle after
   always @(posedge clk) begin
      req_wait <= mem_req_valid && !req_wait;
      rsp_pend <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         rsp_pend <= 1'b1;
         rsp_e    <= mem_req_addr[31];
         rsp_d    <= mem_arr[mem_req_addr[7:2]];
         if (mem_req_write && !mem_req_addr[31])
            mem_arr[mem_req_addr[7:2]] <= mem_req_wdata;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [68:0] act, input logic [68:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compare results and requests against the scoreboard
   rq_t  hold_rq;
   bit   hold_pend = 0;
   always @(negedge clk) begin
      if (rst_n && !timeout) begin
         if (hold_pend)
            check(mem_req_valid && {mem_req_write, mem_req_addr, mem_req_wdata} == hold_rq,
                  "R12 request held", {36'd0, mem_req_valid, mem_req_addr}, {36'd1, hold_rq.addr});
         hold_pend = mem_req_valid && !mem_req_ready;
         hold_rq   = {mem_req_write, mem_req_addr, mem_req_wdata};
         if (mem_req_valid && mem_req_ready) begin
            rq_t got_rq;
            got_rq = {mem_req_write, mem_req_addr, mem_req_wdata};
            reqs++;
            if (rq_q.size() == 0) check(0, "R1 unexpected request", {4'd0, got_rq}, '0);
            else begin
               rq_t want_rq;
               want_rq = rq_q.pop_front();
               check(got_rq == want_rq, "R2/R3/R5/R8 request", {4'd0, got_rq}, {4'd0, want_rq});
            end
         end
         if (wb_valid || cflag_we || align_fault || access_fault) begin
            exp_t got;
            pulses++;
            if (wb_valid)          got = '{kind: 2'(K_WB), idx: wb_idx, val: wb_data};
            else if (cflag_we)     got = '{kind: 2'(K_CF), idx: 5'd0, val: {31'd0, cflag_val}};
            else if (align_fault)  got = '{kind: 2'(K_AL), idx: 5'd0, val: 32'd0};
            else                   got = '{kind: 2'(K_AC), idx: 5'd0, val: 32'd0};
            if (exp_q.size() == 0) check(0, "R1 unexpected result", {30'd0, got}, '0);
            else begin
               exp_t want;
               string t;
               want = exp_q.pop_front();
               t = tag_q.pop_front();
               check(got == want, t, {30'd0, got}, {30'd0, want});
            end
         end
      end
   end

   function automatic logic [31:0] enc_ll(input logic [4:0] rd, input logic [4:0] ra, input logic [15:0] imm);
      return {6'h1B, rd, ra, imm};
   endfunction

   function automatic logic [31:0] enc_sc(input logic [4:0] ra, input logic [4:0] rb, input logic [15:0] imm);
      return {6'h33, imm[15:11], ra, rb, imm[10:0]};
   endfunction

   task automatic push(input int kind, input logic [4:0] idx, input logic [31:0] val, input string tag);
      exp_q.push_back('{kind: 2'(kind), idx: idx, val: val});
      tag_q.push_back(tag);
   endtask

   // driver: predicts from the requirements, then offers the word
   task automatic issue(input logic [31:0] insn, input string tag, input bit hold_kill = 0);
      logic [31:0] ea;
      logic [15:0] imm;
      if (insn[31:26] == 6'h1B) begin
         imm = insn[15:0];
         ea  = regs[insn[20:16]] + {{16{imm[15]}}, imm};
         if (ea[1:0] != 0) push(K_AL, 0, 0, {tag, " R4 misaligned link-load"});
         else begin
            rq_q.push_back('{wr: 1'b0, addr: ea, wd: 32'd0});
            if (ea[31]) push(K_AC, 0, 0, {tag, " R10 read fault"});
            else begin
               push(K_WB, insn[25:21], mem_arr[ea[7:2]], {tag, " R5 write-back"});
               m_flag = 1; m_addr = ea;
            end
         end
      end else if (insn[31:26] == 6'h33) begin
         imm = {insn[25:21], insn[10:0]};
         ea  = regs[insn[20:16]] + {{16{imm[15]}}, imm};
         if (!(m_flag && ea[31:2] == m_addr[31:2])) push(K_CF, 0, 0, {tag, " R6 store refused"});
         else if (ea[1:0] != 0) push(K_AL, 0, 0, {tag, " R7 matched but misaligned"});
         else begin
            rq_q.push_back('{wr: 1'b1, addr: ea, wd: regs[insn[15:11]]});
            if (ea[31]) push(K_AC, 0, 0, {tag, " R10 write fault"});
            else begin
               push(K_CF, 0, 1, {tag, " R8 store done"});
               m_flag = 0;
            end
         end
      end
      if (hold_kill) m_flag = 0;
      @(negedge clk);
      op_valid = 1'b1;
      op_insn  = insn;
      if (hold_kill) exc_taken = 1'b1;
      check(op_ready === 1'b1, {tag, " R11 ready when idle"}, {68'd0, op_ready}, 69'd1);
      @(negedge clk);
      op_valid = 1'b0;
      repeat (8) @(negedge clk);
      exc_taken = 1'b0;
   endtask

   task automatic kill_pulse(input bit use_ctx);
      @(negedge clk);
      if (use_ctx) ctx_switch = 1'b1; else exc_taken = 1'b1;
      @(negedge clk);
      ctx_switch = 1'b0; exc_taken = 1'b0;
      m_flag = 0;
   endtask

   initial begin
      for (int i = 0; i < 32; i++) regs[i] = 32'h0;
      for (int i = 0; i < 64; i++) mem_arr[i] = 32'hA000_0000 + i;
      regs[1] = 32'h0000_0100;
      regs[2] = 32'h0000_0102;
      regs[3] = 32'hDEAD_BEEF;
      regs[4] = 32'h8000_0000;
      regs[5] = 32'h0000_0140;
      regs[6] = 32'h55AA_1234;

      repeat (3) @(negedge clk);
      check(op_ready === 1'b1 && mem_req_valid === 1'b0, "R11 reset idle",
            {67'd0, op_ready, mem_req_valid}, 69'd2);
      check({wb_valid, cflag_we, align_fault, access_fault} === 4'b0, "R11 reset pulses low",
            {65'd0, wb_valid, cflag_we, align_fault, access_fault}, 69'd0);
      rst_n = 1'b1;
      @(negedge clk);

      issue(enc_sc(5'd1, 5'd3, 16'h0000), "R6 no reservation");
      issue(enc_ll(5'd7, 5'd1, 16'h0008), "R2 link-load 0x108");
      issue(enc_sc(5'd5, 5'd3, 16'hFFC8), "R3 split negative offset");
      issue(enc_sc(5'd5, 5'd3, 16'hFFC8), "R8 second store after success");
      issue(enc_ll(5'd8, 5'd1, 16'h0008), "R5 reads stored word");
      issue(enc_sc(5'd2, 5'd6, 16'h0007), "R7 same word, misaligned");
      issue(enc_sc(5'd1, 5'd6, 16'h0010), "R6 other word");
      issue(enc_sc(5'd1, 5'd6, 16'h0008), "R8 store after mismatch");
      issue(enc_ll(5'd9, 5'd2, 16'h0000), "R4 misaligned link-load");
      issue(enc_sc(5'd1, 5'd6, 16'h0000), "R4 no reservation left");
      issue(enc_ll(5'd10, 5'd1, 16'h0004), "R5 link-load 0x104");
      kill_pulse(1'b0);
      issue(enc_sc(5'd1, 5'd6, 16'h0004), "R9 after exception");
      issue(enc_ll(5'd10, 5'd1, 16'h0004), "R5 link-load again");
      kill_pulse(1'b1);
      issue(enc_sc(5'd1, 5'd6, 16'h0004), "R9 after context switch");
      issue(enc_ll(5'd11, 5'd1, 16'h000C), "R9 exception held through load", 1'b1);
      issue(enc_sc(5'd1, 5'd6, 16'h000C), "R9 cancel beats set");
      issue(enc_ll(5'd12, 5'd1, 16'h0010), "R5 link-load 0x110");
      issue(enc_ll(5'd13, 5'd4, 16'h0000), "R10 faulting load");
      issue(enc_sc(5'd1, 5'd3, 16'h0010), "R10 reservation kept");

      begin
         int p0, r0;
         p0 = pulses; r0 = reqs;
         issue(32'h1400_0000 | {6'd0, 5'd1, 5'd1, 16'd8}, "R1 other opcode");
         check(pulses == p0, "R1 no result", 69'(pulses), 69'(p0));
         check(reqs == r0, "R1 no request", 69'(reqs), 69'(r0));
         issue(enc_ll(5'd14, 5'd1, 16'h0018), "R5 link-load 0x118");
         p0 = pulses;
         issue(32'h2C00_0000 | {6'd0, 5'd1, 5'd1, 16'd24}, "R1 other opcode keeps reservation");
         check(pulses == p0, "R1 no result", 69'(pulses), 69'(p0));
         issue(enc_sc(5'd1, 5'd3, 16'h0018), "R1 reservation untouched");
      end

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0 && rq_q.size() == 0, "R5 scoreboard drained",
            69'(exp_q.size() + rq_q.size()), 69'd0);
      if (!timeout) begin
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      timeout = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule